// File: doc/BRIEF.md
# Addressable Latch With Mode Control

This block holds one drive-enable bit for each of eight outputs and updates them from a 3-bit address, a single data bit and two active-low control inputs. A 1 on an output turns the matching sink driver on. The two control inputs choose one of four modes. In latch mode one addressed bit is written. In hold mode every bit keeps its value. In decode mode the addressed bit takes the data bit and every other bit is cleared. In clear mode every bit is erased.

All inputs come from outside the clock domain. Each one passes through a two-stage synchronizer before it is used. The state register is updated from the synchronized values, and the outputs are driven straight from that register. An input pattern that is held steady before a rising edge therefore shows on the outputs after the third rising edge. To keep writes clean, software holds the enable inactive while it moves the address, and then pulses the enable low.

Top module: `addr_latch_drv`

## Requirements
- R1: While rst_ni is low, every bit of drv_on_o is 0.
- R2: An input pattern that is present at a rising edge changes drv_on_o on the third rising edge after it, counting that edge as the first. The path is two synchronizer stages and then the state register.
- R3: Latch mode (clr_ni=1, en_ni=0) sets output bit sel_i to data_i. All other bits keep their values.
- R4: Hold mode (clr_ni=1, en_ni=1) keeps every output bit unchanged, whatever data_i and sel_i do.
- R5: Decode mode (clr_ni=0, en_ni=0) sets output bit sel_i to data_i and sets every other bit to 0.
- R6: Clear mode (clr_ni=0, en_ni=1) sets every output bit to 0, whatever data_i and sel_i are. The stored bits are erased, so a following hold mode also reads 0.
- R7: sel_i is read as an unsigned binary number with bit 0 as the least significant bit. Value n addresses drv_on_o[n].
- R8: data_i=1 turns the addressed driver on (output 1), and data_i=0 turns it off (output 0).
- R9: sel_i must not change while en_ni stays low across consecutive cycles. When en_ni stays low for several cycles at a fixed address, the data value of the last enabled cycle is the one that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Output address, bit 0 least significant |
| data_i | input | 1 | Data bit for the addressed output |
| en_ni | input | 1 | Enable, active low |
| clr_ni | input | 1 | Clear, active low |
| drv_on_o | output | 8 | Drive-enable bits, 1 means the driver is on |

## Verification
The first pattern writes a known, irregular byte into the latch one address at a time. A swapped or shifted address bit then shows up as a wrong output bit, and a write that spills onto other bits shows up as a changed neighbour. Hold mode is then run with data and address toggling, to show that the stored byte is not touched. Decode mode is stepped through every address with data 1 and then with data 0, which separates decode from latch mode because the other bits have to drop. A clear followed by hold checks that the storage is erased and not just masked. A single write timed against the output, followed by a long random run that follows the address protocol, separates correct three-edge latency from designs that are early or late by one edge.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_LATCH = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } mode_e;

  function automatic mode_e mode_of(input logic clr_n, input logic en_n);
    mode_e m;
    case ({clr_n, en_n})
      2'b10:   m = MODE_LATCH;
      2'b11:   m = MODE_HOLD;
      2'b00:   m = MODE_DEMUX;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/addr_latch_sync.sv
module addr_latch_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/addr_latch_dec.sv
module addr_latch_dec #(
  parameter int SEL_W = 3,
  localparam int N    = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     hit_o
);

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit_o[i] = (sel_i == SEL_W'(i));
  end

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_e        mode_i,
  input  logic [N-1:0] hit_i,
  input  logic         data_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o[i] <= 1'b0;
      end else begin
        case (mode_i)
          MODE_LATCH: if (hit_i[i]) q_o[i] <= data_i;
          MODE_DEMUX: q_o[i] <= hit_i[i] & data_i;
          MODE_CLEAR: q_o[i] <= 1'b0;
          default:    q_o[i] <= q_o[i];
        endcase
      end
    end
  end

endmodule

// File: rtl/addr_latch_drv.sv
module addr_latch_drv
  import addr_latch_pkg::*;
#(
  parameter int  SEL_W = 3,
  localparam int N     = 1 << SEL_W,
  localparam int IN_W  = SEL_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             data_i,
  input  logic             en_ni,
  input  logic             clr_ni,
  output logic [N-1:0]     drv_on_o
);

  // reset value of the synchronizer = hold mode, so reset release writes nothing
  localparam logic [IN_W-1:0] IN_IDLE = {1'b1, 1'b1, 1'b0, {SEL_W{1'b0}}};

  logic [IN_W-1:0]  in_sync;
  logic [SEL_W-1:0] sel_s;
  logic             data_s, en_ns, clr_ns;
  logic [N-1:0]     hit;
  mode_e            mode;

  addr_latch_sync #(.W(IN_W), .STAGES(2), .RST_VAL(IN_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({clr_ni, en_ni, data_i, sel_i}),
    .q_o    (in_sync)
  );

  assign {clr_ns, en_ns, data_s, sel_s} = in_sync;
  assign mode = mode_of(clr_ns, en_ns);

  addr_latch_dec #(.SEL_W(SEL_W)) u_dec (
    .sel_i (sel_s),
    .hit_o (hit)
  );

  addr_latch_bank #(.N(N)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .hit_i  (hit),
    .data_i (data_s),
    .q_o    (drv_on_o)
  );

endmodule

// File: rtl/addr_latch_drv_chk.sv
module addr_latch_drv_chk #(
  parameter int  SEL_W = 3,
  localparam int N     = 1 << SEL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic             data_i,
  input logic             en_ni,
  input logic             clr_ni,
  input logic [N-1:0]     drv_on_o
);

  logic [2:0] cyc;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc <= '0;
    else if (cyc != 3'd7)   cyc <= cyc + 3'd1;
  end

  assign warm = (cyc >= 3'd3);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_off_chk: assert (drv_on_o == '0);
  end

  // R6 R2
  clear_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(!clr_ni && en_ni, 3) |-> drv_on_o == '0);

  // R5 R7 R8
  demux_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(!clr_ni && !en_ni, 3) |->
      drv_on_o == (N'($past(data_i, 3)) << $past(sel_i, 3)));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(clr_ni && en_ni, 3) |-> $stable(drv_on_o));

  // R3
  latch_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(clr_ni && !en_ni, 3) |-> drv_on_o[$past(sel_i, 3)] == $past(data_i, 3));

  // R3
  latch_others_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(clr_ni && !en_ni, 3) |-> $countones(drv_on_o ^ $past(drv_on_o)) <= 1);

  // R9
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 3'd0) && !en_ni && $past(!en_ni) |-> $stable(sel_i));

endmodule

bind addr_latch_drv addr_latch_drv_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .data_i   (data_i),
  .en_ni    (en_ni),
  .clr_ni   (clr_ni),
  .drv_on_o (drv_on_o)
);

// File: tb/addr_latch_drv_test.sv
`timescale 1ns/1ps
module addr_latch_drv_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel;
  logic       dat, en_n, clr_n;
  logic [7:0] drv;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  addr_latch_drv uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .data_i(dat),
    .en_ni(en_n), .clr_ni(clr_n), .drv_on_o(drv)
  );

  // reference model: two-deep input history, then the state byte
  logic [5:0] h0, h1;
  logic [7:0] exp_st;
  string      tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_st = 8'h00;
      h0 = 6'b110000;
      h1 = 6'b110000;
      tag = "R1";
    end else begin
      case (h1[5:4])
        2'b10: begin exp_st[h1[2:0]] = h1[3]; tag = "R3"; end
        2'b11: tag = "R4";
        2'b00: begin exp_st = h1[3] ? (8'h01 << h1[2:0]) : 8'h00; tag = "R5"; end
        default: begin exp_st = 8'h00; tag = "R6"; end
      endcase
      h1 = h0;
      h0 = {clr_n, en_n, dat, sel};
    end
  end

  task automatic check(input logic [7:0] exp, input string req);
    tests++;
    if (drv !== exp) begin
      fails++;
      $display("FAIL %s: drv_on_o=%h expected %h at %0t", req, drv, exp, $time);
    end
  endtask

  // drive at a negedge, wait one cycle, compare against the model (R2 timing)
  task automatic apply(input logic [2:0] s, input logic d, input logic e, input logic c);
    sel = s; dat = d; en_n = e; clr_n = c;
    @(negedge clk);
    check(exp_st, {tag, "/R2"});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) apply(sel, dat, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    logic       prev_en;
    rst_n = 1'b0; sel = '0; dat = 1'b0; en_n = 1'b1; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    check(8'h00, "R1");
    rst_n = 1'b1;
    idle(2);

    // R2: a single write appears on the third edge
    apply(3'd5, 1'b0, 1'b1, 1'b1);
    apply(3'd5, 1'b1, 1'b0, 1'b1);
    check(8'h00, "R2 edge1");
    apply(3'd5, 1'b0, 1'b1, 1'b1);
    check(8'h00, "R2 edge2");
    apply(3'd5, 1'b0, 1'b1, 1'b1);
    check(8'h20, "R2 edge3");

    // R3 R7: write an irregular byte address by address
    pat = 8'hB5;
    for (int s = 0; s < 8; s++) begin
      apply(3'(s), 1'b0, 1'b1, 1'b1);
      apply(3'(s), pat[s], 1'b0, 1'b1);
    end
    idle(3);
    check(8'hB5, "R3/R7 byte");
    apply(3'd0, 1'b0, 1'b1, 1'b1);
    apply(3'd0, 1'b0, 1'b0, 1'b1);
    idle(3);
    check(8'hB4, "R3 single bit");

    // R4: hold with data and address toggling
    for (int i = 0; i < 8; i++) apply(3'(7 - i), i[0], 1'b1, 1'b1);
    idle(2);
    check(8'hB4, "R4 hold");

    // R5 R7 R8: decode walk with data 1, then data 0
    for (int s = 0; s < 8; s++) begin
      apply(3'(s), 1'b1, 1'b1, 1'b1);
      apply(3'(s), 1'b1, 1'b0, 1'b0);
      idle(3);
      check(8'h01 << s, "R5/R7 decode one");
    end
    apply(3'd6, 1'b0, 1'b1, 1'b1);
    apply(3'd6, 1'b0, 1'b0, 1'b0);
    idle(3);
    check(8'h00, "R8 data low off");

    // R9: several enabled cycles at one address, last data stays
    apply(3'd1, 1'b0, 1'b1, 1'b1);
    apply(3'd1, 1'b0, 1'b0, 1'b1);
    apply(3'd1, 1'b0, 1'b0, 1'b1);
    apply(3'd1, 1'b1, 1'b0, 1'b1);
    idle(3);
    check(8'h02, "R9 last write");

    // R6: clear with noisy data/address erases storage
    apply(3'd7, 1'b1, 1'b1, 1'b1);
    apply(3'd7, 1'b1, 1'b0, 1'b1);
    idle(3);
    check(8'h82, "R3 setup");
    apply(3'd4, 1'b1, 1'b1, 1'b0);
    apply(3'd2, 1'b0, 1'b1, 1'b0);
    idle(4);
    check(8'h00, "R6 cleared");

    // random run obeying the address protocol
    prev_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic e;
      logic [2:0] s;
      e = 1'($urandom % 2);
      s = (!prev_en && !e) ? sel : 3'($urandom % 8);
      apply(s, 1'($urandom % 2), e, 1'(($urandom % 4) != 0));
      prev_en = e;
    end
    idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule